// File: doc/BRIEF.md
# Bus Status Command Decoder

This block sits beside a processor that runs in its multi-master mode and drives only a 3-bit status code instead of separate bus strobes. The decoder rebuilds the individual commands from that code. These are memory read, memory write, I/O read, I/O write and interrupt acknowledge. It also produces the address-latch pulse, the data-buffer enable and the data-buffer direction that the rest of the board needs.

The all-ones status code is the passive code, meaning no bus cycle. A bus cycle begins on the first clock where the sampled status moves from passive to any other code. The block then gives a one-clock latch pulse, asserts the matching command one clock later, and holds that command until it samples passive again. The code is captured when the cycle begins. Any other code that arrives before the passive code is ignored. Halt starts a cycle with a latch pulse but produces no command.

Top module: `stat_cmd_decoder`

## Requirements
- R1: While `rstN` is low, and after its release until a cycle starts, every command output is high (inactive), `latchStb` is 0, `dataEnable` is 0 and `dataDirTx` is 0.
- R2: When the decoder is idle and a clock edge samples `statusIn` other than 3'b111, `latchStb` is 1 for exactly the one clock period after that edge.
- R3: The command for the captured code goes low at the edge after the latch edge. It stays low until an edge samples `statusIn` = 3'b111, and it returns high right after that edge.
- R4: Code 3'b000 drives `intAckN` low, 3'b001 drives `ioRdN` low, 3'b010 drives `ioWrN` low, 3'b101 drives `memRdN` low, and 3'b110 drives `memWrN` low.
- R5: Code 3'b100 (instruction fetch) drives `memRdN` low, exactly as a memory read does.
- R6: Code 3'b011 (halt) gives the latch pulse but no command and no `dataEnable`. Code 3'b111 while idle gives no output change at all.
- R7: `dataDirTx` is 1 from the latch clock to the end of the cycle for codes 3'b010 and 3'b110, and 0 in every other case.
- R8: `dataEnable` is 1 in exactly the clocks in which a command output is low.
- R9: A change of `statusIn` to a different non-passive code during a cycle does not change the command or the direction until the passive code is sampled.
- R10: If the passive code is sampled on the edge right after the latch edge, the cycle ends with no command asserted.
- R11: At most one command output is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| statusIn | input | 3 | Status code from the processor; 3'b111 is passive |
| latchStb | output | 1 | One-clock address-latch pulse at cycle start |
| dataEnable | output | 1 | Data buffer enable, active high |
| dataDirTx | output | 1 | Data buffer direction: 1 transmit, 0 receive |
| intAckN | output | 1 | Interrupt acknowledge command, active low |
| ioRdN | output | 1 | I/O read command, active low |
| ioWrN | output | 1 | I/O write command, active low |
| memRdN | output | 1 | Memory read command, active low |
| memWrN | output | 1 | Memory write command, active low |

## Verification
Assertions check several properties on every clock:
- at most one command is low;
- the latch pulse never lasts two clocks;
- a command only starts on the clock after a latch pulse;
- the transmit direction never coincides with a read or acknowledge command;
- a sampled passive code always returns the control to idle.

Other behaviours need the directed scenarios in the bench:
- the mapping of each of the eight codes to its specific command;
- the exact clock in which each strobe rises and falls;
- that a mid-cycle code change is ignored;
- that a one-clock cycle produces no command.

// File: rtl/busdec_pkg.sv
package busdec_pkg;

  localparam int STAT_W = 3;
  localparam int CMD_N  = 5;

  // command bit positions inside the one-hot command vector
  localparam int CMD_INTA = 4;
  localparam int CMD_IORD = 3;
  localparam int CMD_IOWR = 2;
  localparam int CMD_MRD  = 1;
  localparam int CMD_MWR  = 0;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_CMD  = 2'd2
  } phase_t;

  // strobes from control to datapath, valid for the coming edge
  typedef struct packed {
    logic loadCode;   // capture the status code at this edge
    logic nextAddr;   // latch phase follows this edge
    logic nextCmd;    // command phase follows this edge
    logic nextActive; // a cycle is open after this edge
  } ctrlStrb_t;

  function automatic logic [CMD_N-1:0] cmdOf(input logic [STAT_W-1:0] code);
    logic [CMD_N-1:0] sel;
    sel = '0;
    unique case (code)
      3'b000:  sel[CMD_INTA] = 1'b1;
      3'b001:  sel[CMD_IORD] = 1'b1;
      3'b010:  sel[CMD_IOWR] = 1'b1;
      3'b100:  sel[CMD_MRD]  = 1'b1;
      3'b101:  sel[CMD_MRD]  = 1'b1;
      3'b110:  sel[CMD_MWR]  = 1'b1;
      default: sel = '0;
    endcase
    return sel;
  endfunction

  function automatic logic isWrite(input logic [STAT_W-1:0] code);
    return (code == 3'b010) || (code == 3'b110);
  endfunction

endpackage

// File: rtl/busdec_ctrl.sv
module busdec_ctrl
  import busdec_pkg::*;
#(
  parameter logic [STAT_W-1:0] PASSIVE = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [STAT_W-1:0] statusIn,
  output ctrlStrb_t         strb
);

  phase_t phase, phaseNext;
  logic   passiveNow;

  assign passiveNow = (statusIn == PASSIVE);

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: if (!passiveNow) phaseNext = PH_ADDR;
      PH_ADDR: phaseNext = passiveNow ? PH_IDLE : PH_CMD;
      PH_CMD:  if (passiveNow) phaseNext = PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_comb begin
    strb.loadCode   = (phase == PH_IDLE) && !passiveNow;
    strb.nextAddr   = (phaseNext == PH_ADDR);
    strb.nextCmd    = (phaseNext == PH_CMD);
    strb.nextActive = (phaseNext != PH_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  // R2: the latch phase never lasts two clocks
  p_latch_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_ADDR) |=> (phase != PH_ADDR));

  // R3: a sampled passive code always closes the cycle
  p_passive_ends_r3: assert property (@(posedge clk) disable iff (!rstN)
    passiveNow |=> (phase == PH_IDLE));

endmodule

// File: rtl/busdec_dp.sv
module busdec_dp
  import busdec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [STAT_W-1:0] statusIn,
  input  ctrlStrb_t         strb,
  output logic              latchStb,
  output logic              dataEnable,
  output logic              dataDirTx,
  output logic [CMD_N-1:0]  cmdN
);

  logic [STAT_W-1:0] codeReg, codeNext;
  logic [CMD_N-1:0]  cmdSel;

  assign codeNext = strb.loadCode ? statusIn : codeReg;
  assign cmdSel   = cmdOf(codeNext) & {CMD_N{strb.nextCmd}};

  always_ff @(posedge clk) begin
    if (!rstN) codeReg <= '1;
    else       codeReg <= codeNext;
  end

  genvar gi;
  generate
    for (gi = 0; gi < CMD_N; gi++) begin : g_cmd
      always_ff @(posedge clk) begin
        if (!rstN) cmdN[gi] <= 1'b1;
        else       cmdN[gi] <= ~cmdSel[gi];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchStb   <= 1'b0;
      dataEnable <= 1'b0;
      dataDirTx  <= 1'b0;
    end else begin
      latchStb   <= strb.nextAddr;
      dataEnable <= |cmdSel;
      dataDirTx  <= strb.nextActive && isWrite(codeNext);
    end
  end

  // R11: never more than one command low
  p_one_cmd_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~cmdN));

  // R3: a command only begins on the clock after the latch pulse
  p_cmd_after_latch_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(&cmdN) |-> $past(latchStb)));

  // R7: the transmit direction never coincides with a read or acknowledge
  p_dir_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    dataDirTx |-> (cmdN[CMD_INTA] && cmdN[CMD_IORD] && cmdN[CMD_MRD]));

  // R8: the data enable is never high while all commands are idle
  p_de_cmd_r8: assert property (@(posedge clk) disable iff (!rstN)
    dataEnable |-> !(&cmdN));

endmodule

// File: rtl/stat_cmd_decoder.sv
module stat_cmd_decoder
  import busdec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] statusIn,
  output logic       latchStb,
  output logic       dataEnable,
  output logic       dataDirTx,
  output logic       intAckN,
  output logic       ioRdN,
  output logic       ioWrN,
  output logic       memRdN,
  output logic       memWrN
);

  ctrlStrb_t        strb;
  logic [CMD_N-1:0] cmdN;

  busdec_ctrl #(.PASSIVE(3'b111)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .statusIn (statusIn),
    .strb     (strb)
  );

  busdec_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .statusIn   (statusIn),
    .strb       (strb),
    .latchStb   (latchStb),
    .dataEnable (dataEnable),
    .dataDirTx  (dataDirTx),
    .cmdN       (cmdN)
  );

  assign intAckN = cmdN[CMD_INTA];
  assign ioRdN   = cmdN[CMD_IORD];
  assign ioWrN   = cmdN[CMD_IOWR];
  assign memRdN  = cmdN[CMD_MRD];
  assign memWrN  = cmdN[CMD_MWR];

endmodule

// File: tb/sim_stat_cmd_decoder.sv
`timescale 1ns/1ps
module sim_stat_cmd_decoder;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] statusIn = 3'b111;
  logic       latchStb, dataEnable, dataDirTx;
  logic       intAckN, ioRdN, ioWrN, memRdN, memWrN;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  stat_cmd_decoder u0 (
    .clk(clk), .rstN(rstN), .statusIn(statusIn),
    .latchStb(latchStb), .dataEnable(dataEnable), .dataDirTx(dataDirTx),
    .intAckN(intAckN), .ioRdN(ioRdN), .ioWrN(ioWrN),
    .memRdN(memRdN), .memWrN(memWrN)
  );

  // observed vector: latch, enable, dir, intAckN, ioRdN, ioWrN, memRdN, memWrN
  function automatic logic [7:0] obs();
    return {latchStb, dataEnable, dataDirTx, intAckN, ioRdN, ioWrN, memRdN, memWrN};
  endfunction

  // active-high command map in the order intAck, ioRd, ioWr, memRd, memWr
  function automatic logic [4:0] expMap(input logic [2:0] c);
    case (c)
      3'b000:  return 5'b10000;
      3'b001:  return 5'b01000;
      3'b010:  return 5'b00100;
      3'b100:  return 5'b00010;
      3'b101:  return 5'b00010;
      3'b110:  return 5'b00001;
      default: return 5'b00000;
    endcase
  endfunction

  function automatic logic expWr(input logic [2:0] c);
    return (c == 3'b010) || (c == 3'b110);
  endfunction

  function automatic logic [7:0] expIdle();
    return 8'b000_11111;
  endfunction

  function automatic logic [7:0] expLatch(input logic [2:0] c);
    return {1'b1, 1'b0, expWr(c), 5'b11111};
  endfunction

  function automatic logic [7:0] expCmd(input logic [2:0] c);
    return {1'b0, |expMap(c), expWr(c), ~expMap(c)};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
    total++;
    if ($countones(~act[4:0]) > 1) begin
      bad++;
      $display("FAIL R11 actual=%b expected=at most one low command", act[4:0]);
    end
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    statusIn = 3'b101;
    tick();
    chk("R1 during reset", obs(), expIdle());
    statusIn = 3'b111;
    rstN = 1'b1;
    tick();
    chk("R1 after release", obs(), expIdle());
  endtask

  // full cycle for one code, held for hold command clocks
  task automatic t_cycle(input logic [2:0] c, input int hold);
    statusIn = c;
    tick();
    chk($sformatf("R2 R7 latch code %b", c), obs(), expLatch(c));
    for (int k = 0; k < hold; k++) begin
      tick();
      chk($sformatf("R3 R4 R5 R6 R8 cmd code %b", c), obs(), expCmd(c));
    end
    statusIn = 3'b111;
    tick();
    chk($sformatf("R3 end code %b", c), obs(), expIdle());
  endtask

  task automatic t_passiveIdle();
    statusIn = 3'b111;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R6 passive idle", obs(), expIdle());
    end
  endtask

  task automatic t_midChange();
    statusIn = 3'b001;
    tick();
    chk("R9 latch", obs(), expLatch(3'b001));
    tick();
    chk("R9 cmd", obs(), expCmd(3'b001));
    statusIn = 3'b110;
    tick();
    chk("R9 ignored change", obs(), expCmd(3'b001));
    statusIn = 3'b000;
    tick();
    chk("R9 ignored change 2", obs(), expCmd(3'b001));
    statusIn = 3'b111;
    tick();
    chk("R9 end", obs(), expIdle());
  endtask

  task automatic t_shortCycle();
    statusIn = 3'b110;
    tick();
    chk("R10 latch", obs(), expLatch(3'b110));
    statusIn = 3'b111;
    tick();
    chk("R10 no command", obs(), expIdle());
    tick();
    chk("R10 stays idle", obs(), expIdle());
  endtask

  task automatic t_backToBack();
    t_cycle(3'b010, 1);
    t_cycle(3'b101, 2);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_passiveIdle();
    for (int c = 0; c < 7; c++) t_cycle(c[2:0], 3);
    t_cycle(3'b100, 1);
    t_midChange();
    t_shortCycle();
    t_backToBack();
    t_reset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule